// File: doc/BRIEF.md
# Mirrored Polyphase Coefficient Store

This block keeps the filter coefficients for a 64-phase polyphase video scaler. The coefficient set is symmetric, so only phases 0 through 32 are kept in storage. A read at any phase above 32 is answered from the matching stored phase with the tap order reversed. There are four separate tables, one per filter type: luma vertical, chroma vertical, luma horizontal and chroma horizontal.

Software loads coefficients through a write port. Each write carries a filter type, a phase, a tap-pair index and one data word. The data word holds an even coefficient and an odd coefficient, and each of the two has its own enable bit. All writes land in a shadow bank. When loading is finished, a single-cycle commit strobe copies the shadow bank into the active bank, and the active bank is what the filter datapath reads.

The storage starts out power-gated. A power-disable input has to be held high for a fixed wake-up time before the storage reports itself awake, and writes are only accepted while it is awake.

Top module: `coef_mirror_store`

## Requirements
- R1: After reset, `mem_awake`, `wr_ready` and `rsp_valid` are low, and every read of either bank returns zero.
- R2: When `pwr_dis` is sampled high on WAKE_CYCLES consecutive rising edges (default 4), `mem_awake` goes high at the last of those edges. A single edge that samples `pwr_dis` low drives `mem_awake` low. `wr_ready` always equals `mem_awake`.
- R3: A write presented while `wr_ready` is low changes no stored coefficient.
- R4: Write data fields are placed as follows:
  - `wr_data[15:0]` is the even coefficient and bit 16 is its enable.
  - `wr_data[32:17]` is the odd coefficient and bit 33 is its enable.
  - Pair index p writes tap 2p from the even field and tap 2p+1 from the odd field.
  - Each slot is written only when its own enable bit is set.
- R5: The four tables are independent. Type codes are 0 luma vertical, 1 chroma vertical, 2 luma horizontal and 3 chroma horizontal. A write to one type never changes another type.
- R6: Writes go only to the shadow bank. A `commit` pulse sampled at rising edge E copies the shadow bank into the active bank at edge E+1. A read sampled at E or at E+1 returns the old contents, and a read sampled at E+2 or later returns the new contents.
- R7: A read at phase k ≤ 32 returns stored phase k, tap t. A read at phase k > 32 returns stored phase 64−k, tap 3−t. Phases 0 and 32 are never mirrored.
- R8: A write with phase above 32 is accepted but changes no stored coefficient.
- R9: A read request (`rd_valid`) is always accepted. `rsp_valid` and `rsp_data` follow one rising edge later.
- R10: The commit copies the shadow bank and leaves it intact. A slot whose enable was clear keeps its earlier value in both banks across later commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dis | input | 1 | Hold high to take the storage out of power gating |
| mem_awake | output | 1 | Storage is powered and writable |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted this cycle (equals `mem_awake`) |
| wr_type | input | 2 | Filter type of the write |
| wr_phase | input | 6 | Phase of the write (0..63) |
| wr_pair | input | 1 | Tap-pair index |
| wr_data | input | 34 | Even/odd coefficients with enables (see R4) |
| commit | input | 1 | Update-complete strobe |
| rd_valid | input | 1 | Read request, no back-pressure |
| rd_type | input | 2 | Filter type of the read |
| rd_phase | input | 6 | Read phase (0..63) |
| rd_tap | input | 2 | Read tap index (0..3) |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Coefficient read from the active bank |

## Verification
Each result becomes due a fixed number of rising edges after its stimulus:
- A read response is due one edge after the request.
- The awake flag rises at the fourth edge of `pwr_dis` held high, and falls one edge after `pwr_dis` drops.
- A committed bank becomes visible to reads sampled two edges after the strobe.

The bench drives every input just after a falling edge and checks outputs at the next falling edge, once exactly the required number of rising edges has passed. It probes the commit window by reading in the strobe cycle, the cycle after it, and the cycle after that.

// File: rtl/coef_store_pkg.sv
package coef_store_pkg;

  typedef enum logic [1:0] {
    FT_LUMA_V   = 2'd0,
    FT_CHROMA_V = 2'd1,
    FT_LUMA_H   = 2'd2,
    FT_CHROMA_H = 2'd3
  } filt_sel_e;

  // Phases above the midpoint fold back onto the stored half.
  function automatic int fold_phase(input int phases, input int k);
    return (k > phases / 2) ? phases - k : k;
  endfunction

  // Folded phases see their taps in reverse order.
  function automatic int fold_tap(input int phases, input int taps, input int k, input int t);
    return (k > phases / 2) ? taps - 1 - t : t;
  endfunction

endpackage

// File: rtl/coef_pwr_seq.sv
module coef_pwr_seq #(
  parameter int WAKE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dis,
  output logic awake
);
  localparam int CNTW = $clog2(WAKE_CYCLES + 1);

  logic [CNTW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      awake <= 1'b0;
    end else if (!pwr_dis) begin
      cnt_q <= '0;
      awake <= 1'b0;
    end else if (!awake) begin
      if (cnt_q == CNTW'(WAKE_CYCLES - 1)) awake <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_gate_on_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dis |=> !awake);

  assert_wake_needs_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(awake) |-> $past(pwr_dis));

endmodule

// File: rtl/coef_addr_map.sv
module coef_addr_map #(
  parameter int PHASES = 64,
  parameter int TAPS   = 4,
  localparam int PW     = $clog2(PHASES),
  localparam int TW     = $clog2(TAPS),
  localparam int STORED = PHASES / 2 + 1,
  localparam int SPW    = $clog2(STORED)
) (
  input  logic [PW-1:0]  phase,
  input  logic [TW-1:0]  tap,
  output logic [SPW-1:0] st_phase,
  output logic [TW-1:0]  st_tap
);
  always_comb begin
    st_phase = SPW'(coef_store_pkg::fold_phase(PHASES, int'(phase)));
    st_tap   = TW'(coef_store_pkg::fold_tap(PHASES, TAPS, int'(phase), int'(tap)));
  end
endmodule

// File: rtl/coef_bank.sv
module coef_bank #(
  parameter int NTYPES = 4,
  parameter int STORED = 33,
  parameter int TAPS   = 4,
  parameter int CW     = 16,
  localparam int TYW     = $clog2(NTYPES),
  localparam int SPW     = $clog2(STORED),
  localparam int TW      = $clog2(TAPS),
  localparam int PAIRS   = (TAPS + 1) / 2,
  localparam int PRW     = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int ENTRIES = NTYPES * STORED * TAPS,
  localparam int IW      = $clog2(ENTRIES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [TYW-1:0] wr_type,
  input  logic [SPW-1:0] wr_phase,
  input  logic [PRW-1:0] wr_pair,
  input  logic           even_en,
  input  logic [CW-1:0]  even_val,
  input  logic           odd_en,
  input  logic [CW-1:0]  odd_val,
  input  logic           commit,
  input  logic           rd_valid,
  input  logic [TYW-1:0] rd_type,
  input  logic [SPW-1:0] rd_phase,
  input  logic [TW-1:0]  rd_tap,
  output logic           rsp_valid,
  output logic [CW-1:0]  rsp_data
);
  logic [CW-1:0] shadow_q [ENTRIES];
  logic [CW-1:0] active_q [ENTRIES];
  logic          pend_q;

  function automatic logic [IW-1:0] flat(input int ty, input int ph, input int tp);
    return IW'((ty * STORED + ph) * TAPS + tp);
  endfunction

  logic [IW-1:0] even_idx, odd_idx, rd_idx;
  logic          addr_ok, odd_exists;

  always_comb begin
    even_idx   = flat(int'(wr_type), int'(wr_phase), 2 * int'(wr_pair));
    odd_idx    = flat(int'(wr_type), int'(wr_phase), 2 * int'(wr_pair) + 1);
    addr_ok    = (int'(wr_type) < NTYPES) && (int'(wr_pair) < PAIRS);
    odd_exists = (2 * int'(wr_pair) + 1) < TAPS;
    rd_idx     = flat(int'(rd_type), int'(rd_phase), int'(rd_tap));
  end

  // Shadow bank: loaded pair by pair, each slot under its own enable.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) shadow_q[i] <= '0;
    end else if (wr_en && addr_ok) begin
      if (even_en) shadow_q[even_idx] <= even_val;
      if (odd_en && odd_exists) shadow_q[odd_idx] <= odd_val;
    end
  end

  // Commit is registered once, then the whole shadow bank is copied.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) active_q[i] <= '0;
    end else begin
      pend_q <= commit;
      if (pend_q) begin
        for (int i = 0; i < ENTRIES; i++) active_q[i] <= shadow_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp_data <= active_q[rd_idx];
    end
  end

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

  assert_active_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> $stable(active_q[0]));

  assert_shadow_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(shadow_q[0]));

  assert_folded_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (int'(rd_phase) < STORED));

endmodule

// File: rtl/coef_mirror_store.sv
module coef_mirror_store #(
  parameter int NTYPES      = 4,
  parameter int PHASES      = 64,
  parameter int TAPS        = 4,
  parameter int CW          = 16,
  parameter int WAKE_CYCLES = 4,
  localparam int TYW    = $clog2(NTYPES),
  localparam int PW     = $clog2(PHASES),
  localparam int TW     = $clog2(TAPS),
  localparam int PAIRS  = (TAPS + 1) / 2,
  localparam int PRW    = (PAIRS > 1) ? $clog2(PAIRS) : 1,
  localparam int HALF   = PHASES / 2,
  localparam int STORED = HALF + 1,
  localparam int SPW    = $clog2(STORED),
  localparam int DW     = 2 * CW + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pwr_dis,
  output logic           mem_awake,
  input  logic           wr_valid,
  output logic           wr_ready,
  input  logic [TYW-1:0] wr_type,
  input  logic [PW-1:0]  wr_phase,
  input  logic [PRW-1:0] wr_pair,
  input  logic [DW-1:0]  wr_data,
  input  logic           commit,
  input  logic           rd_valid,
  input  logic [TYW-1:0] rd_type,
  input  logic [PW-1:0]  rd_phase,
  input  logic [TW-1:0]  rd_tap,
  output logic           rsp_valid,
  output logic [CW-1:0]  rsp_data
);
  logic           bank_wr_en;
  logic [SPW-1:0] rd_st_phase;
  logic [TW-1:0]  rd_st_tap;

  coef_pwr_seq #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
    .clk(clk), .rst_n(rst_n), .pwr_dis(pwr_dis), .awake(mem_awake)
  );

  assign wr_ready   = mem_awake;
  assign bank_wr_en = wr_valid && wr_ready && (int'(wr_phase) <= HALF);

  coef_addr_map #(.PHASES(PHASES), .TAPS(TAPS)) u_map (
    .phase(rd_phase), .tap(rd_tap), .st_phase(rd_st_phase), .st_tap(rd_st_tap)
  );

  coef_bank #(.NTYPES(NTYPES), .STORED(STORED), .TAPS(TAPS), .CW(CW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bank_wr_en),
    .wr_type  (wr_type),
    .wr_phase (wr_phase[SPW-1:0]),
    .wr_pair  (wr_pair),
    .even_en  (wr_data[CW]),
    .even_val (wr_data[CW-1:0]),
    .odd_en   (wr_data[2*CW+1]),
    .odd_val  (wr_data[2*CW:CW+1]),
    .commit   (commit),
    .rd_valid (rd_valid),
    .rd_type  (rd_type),
    .rd_phase (rd_st_phase),
    .rd_tap   (rd_st_tap),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  assert_gated_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !mem_awake) |-> !bank_wr_en);

  assert_upper_phase_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && int'(wr_phase) > HALF) |-> !bank_wr_en);

endmodule

// File: tb/sim_coef_mirror_store.sv
module sim_coef_mirror_store;
  import coef_store_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_dis = 1'b0;
  logic mem_awake, wr_ready, rsp_valid;
  logic wr_valid = 1'b0;
  logic [1:0] wr_type = '0;
  logic [5:0] wr_phase = '0;
  logic wr_pair = 1'b0;
  logic [33:0] wr_data = '0;
  logic commit = 1'b0;
  logic rd_valid = 1'b0;
  logic [1:0] rd_type = '0;
  logic [5:0] rd_phase = '0;
  logic [1:0] rd_tap = '0;
  logic [15:0] rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_sh [4][33][4];
  logic [15:0] m_ac [4][33][4];

  always #4 clk = ~clk;

  coef_mirror_store u0 (
    .clk(clk), .rst_n(rst_n), .pwr_dis(pwr_dis), .mem_awake(mem_awake),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_type(wr_type),
    .wr_phase(wr_phase), .wr_pair(wr_pair), .wr_data(wr_data),
    .commit(commit), .rd_valid(rd_valid), .rd_type(rd_type),
    .rd_phase(rd_phase), .rd_tap(rd_tap), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int ty, input int ph, input int tp);
    if (ph > 32) return m_ac[ty][64 - ph][3 - tp];
    return m_ac[ty][ph][tp];
  endfunction

  // Starts and ends just after a falling edge.
  task automatic do_write(input int ty, input int ph, input int pr, input bit een,
                          input logic [15:0] ev, input bit oen, input logic [15:0] ov,
                          input bit exp_rdy, input string req);
    wr_valid = 1'b1; wr_type = 2'(ty); wr_phase = 6'(ph); wr_pair = 1'(pr);
    wr_data = {oen, ov, een, ev};
    check(wr_ready == exp_rdy, req, wr_ready, exp_rdy);
    @(posedge clk);
    if (exp_rdy && ph <= 32) begin
      if (een) m_sh[ty][ph][2*pr] = ev;
      if (oen) m_sh[ty][ph][2*pr+1] = ov;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input int ty, input int ph, input int tp,
                         input logic [15:0] expv, input string req);
    rd_valid = 1'b1; rd_type = 2'(ty); rd_phase = 6'(ph); rd_tap = 2'(tp);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_data === expv, req, rsp_data, expv);
  endtask

  task automatic do_commit();
    commit = 1'b1;
    @(posedge clk);
    @(negedge clk);
    commit = 1'b0;
    @(posedge clk);
    @(negedge clk);
    m_ac = m_sh;
  endtask

  task automatic wake();
    pwr_dis = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 33; b++)
        for (int c = 0; c < 4; c++) begin m_sh[a][b][c] = '0; m_ac[a][b][c] = '0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(mem_awake == 1'b0, "R1 awake", mem_awake, 0);
    check(wr_ready == 1'b0, "R1 ready", wr_ready, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);

    // R2: wake timing
    pwr_dis = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_awake == 1'b0, "R2 early", mem_awake, 0);
    @(posedge clk);
    @(negedge clk);
    check(mem_awake == 1'b1, "R2 wake", mem_awake, 1);
    check(wr_ready == 1'b1, "R2 ready", wr_ready, 1);

    do_read(FT_LUMA_H, 0, 0, 16'h0, "R1 zero bank");
    do_read(FT_CHROMA_V, 45, 2, 16'h0, "R1 zero bank mirrored");

    // R4 and R6: shadow isolation, then the commit window
    do_write(FT_LUMA_H, 32, 0, 1, 16'h1111, 1, 16'h2222, 1, "R2 ready");
    do_write(FT_LUMA_H, 32, 1, 1, 16'h3333, 1, 16'h4444, 1, "R2 ready");
    do_read(FT_LUMA_H, 32, 1, 16'h0, "R6 shadow hidden");
    commit = 1'b1;
    rd_valid = 1'b1; rd_type = FT_LUMA_H; rd_phase = 6'd32; rd_tap = 2'd1;
    @(posedge clk);
    @(negedge clk);
    commit = 1'b0;
    check(rsp_data == 16'h0, "R6 strobe cycle old", rsp_data, 0);
    @(posedge clk);
    @(negedge clk);
    check(rsp_data == 16'h0, "R6 next cycle old", rsp_data, 0);
    @(posedge clk);
    @(negedge clk);
    rd_valid = 1'b0;
    check(rsp_data == 16'h2222, "R6 new bank", rsp_data, 16'h2222);
    m_ac = m_sh;
    do_read(FT_LUMA_H, 32, 3, 16'h4444, "R4 odd slot pair1");
    do_read(FT_LUMA_H, 32, 2, 16'h3333, "R4 even slot pair1");

    // R10: cleared odd enable keeps old slot
    do_write(FT_LUMA_H, 32, 1, 1, 16'h5555, 0, 16'hFFFF, 1, "R2 ready");
    do_commit();
    do_read(FT_LUMA_H, 32, 3, 16'h4444, "R10 odd kept");
    do_read(FT_LUMA_H, 32, 2, 16'h5555, "R10 even updated");
    do_commit();
    do_read(FT_LUMA_H, 32, 3, 16'h4444, "R10 kept after recommit");

    // R7: mirrored read
    do_write(FT_CHROMA_V, 10, 0, 1, 16'h00A0, 1, 16'h00A1, 1, "R2 ready");
    do_write(FT_CHROMA_V, 10, 1, 1, 16'h00A2, 1, 16'h00A3, 1, "R2 ready");
    do_commit();
    do_read(FT_CHROMA_V, 54, 0, 16'h00A3, "R7 mirror tap0");
    do_read(FT_CHROMA_V, 54, 2, 16'h00A1, "R7 mirror tap2");
    do_read(FT_CHROMA_V, 10, 0, 16'h00A0, "R7 direct");

    // R8: upper phase write ignored
    do_write(FT_CHROMA_V, 40, 0, 1, 16'hBEEF, 1, 16'hBEEF, 1, "R2 ready");
    do_commit();
    do_read(FT_CHROMA_V, 24, 0, 16'h0, "R8 phase24 untouched");
    do_read(FT_CHROMA_V, 40, 3, 16'h0, "R8 phase40 reads zero");

    // R5: tables independent
    do_write(FT_CHROMA_H, 10, 0, 1, 16'h7777, 0, 16'h0, 1, "R2 ready");
    do_commit();
    do_read(FT_CHROMA_H, 10, 0, 16'h7777, "R5 type3");
    do_read(FT_CHROMA_V, 10, 0, 16'h00A0, "R5 type1 untouched");

    // R3: gated writes refused
    pwr_dis = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(mem_awake == 1'b0, "R2 drop", mem_awake, 0);
    do_write(FT_CHROMA_V, 10, 0, 1, 16'hDEAD, 1, 16'hDEAD, 0, "R3 ready low");
    wake();
    do_commit();
    do_read(FT_CHROMA_V, 10, 0, 16'h00A0, "R3 gated write ignored");
    do_read(FT_CHROMA_V, 10, 1, 16'h00A1, "R3 gated write ignored");

    // Random rounds: R4 R5 R6 R7 R8 R10
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int w = 0; w < 80; w++)
        do_write(int'($urandom % 4), int'($urandom % 64), int'($urandom % 2),
                 1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom), 1, "R2 ready");
      do_commit();
      for (int w = 0; w < 20; w++)
        do_write(int'($urandom % 4), int'($urandom % 33), int'($urandom % 2),
                 1'b1, 16'($urandom), 1'b1, 16'($urandom), 1, "R2 ready");
      for (int r = 0; r < 50; r++) begin
        int ty, ph, tp;
        ty = int'($urandom % 4); ph = int'($urandom % 64); tp = int'($urandom % 4);
        do_read(ty, ph, tp, exp_rd(ty, ph, tp), "R7 random read");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule